// File: doc/BRIEF.md
# SMM Memory Access Control Register

This block holds an 8-bit configuration register that decides who may reach the DRAM behind the 128 KB compatible window at A0000h–BFFFFh. For every memory request it decides whether the request goes to the protected DRAM or to the legacy video path. Each request carries an address, a flag that marks system-management mode (SMM), and a flag that tells an instruction fetch apart from a data access. The register sits at configuration offset 9Dh. It is written through a simple configuration write port and read back through a combinational read port.

Firmware first sets the global enable bit. It can then set the open bit, so that the window becomes reachable outside SMM while it fills SMM memory. Once that work is done, it sets the lock bit. A lock turns off the open bit and freezes the enable, open and lock fields until a full reset. The lock state also leaves the block on its own pin, so that neighbouring registers can freeze along with it. The closed bit stays writable at all times. It keeps SMM data accesses away from the DRAM while SMM instruction fetches still reach it, which lets handler code draw to the display through the same range.

Top module: `smram_guard`

## Requirements
- R1: After a full reset the register at offset 9Dh reads 02h and lockOut is 0.
- R2: While unlocked, a write to 9Dh loads bit 6 (open), bit 5 (closed), bit 4 (lock) and bit 3 (global enable). Bit 7 always reads 0 and bits 2:0 always read 010b. Any other offset reads 00h, and writes to other offsets change nothing.
- R3: A request with an address outside A0000h–BFFFFh drives neither routeDram nor routeVideo. A request inside the window drives exactly one of them.
- R4: With global enable at 0, every request inside the window goes to video, whatever the open, closed, SMM and fetch flags are.
- R5: With global enable at 1, an SMM instruction fetch (reqCode=1) in the window goes to DRAM. An SMM data access goes to DRAM only when closed is 0.
- R6: With global enable at 1, a non-SMM request in the window goes to DRAM only when open is 1 and lock is 0. Otherwise it goes to video.
- R7: When open and closed are both 1 and the register is unlocked, a non-SMM data access goes to DRAM, an SMM data access goes to video, and an SMM instruction fetch goes to DRAM. No fault is raised.
- R8: A write that sets bit 4 raises lockOut and leaves open at 0 in the same write, even when bit 6 of the data is 1.
- R9: While locked, writes leave open, lock and global enable unchanged, and closed still follows bit 5 of each write.
- R10: Writing 0 to bit 4 never clears the lock. Only the full reset returns lockOut to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstFullN | input | 1 | Full reset, asynchronous, active low |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 8 | Configuration offset for both read and write |
| cfgWrData | input | 8 | Configuration write data |
| cfgRdData | output | 8 | Combinational read data for cfgAddr |
| reqAddr | input | 32 | Memory request address |
| reqSmm | input | 1 | Request is issued in SMM |
| reqCode | input | 1 | 1 = instruction fetch, 0 = data access |
| routeDram | output | 1 | Request goes to the protected DRAM |
| routeVideo | output | 1 | Request inside the window goes to the video path |
| lockOut | output | 1 | Lock state exported to related registers |

## Verification
The bench steps through all eight unlocked settings of open, closed and enable. Under each setting it applies addresses just below, at the start of, inside, at the end of and just past the window, combined with every SMM and fetch flag. This separates enable gating, the SMM fetch-versus-data split and the open override, and it covers the illegal open-plus-closed setting. A locked pass repeats the sweep to show that the open override is gone, that closed stays writable and that lock survives writes of 0. A final reset shows that only the full reset releases the lock.

// File: rtl/smram_pkg.sv
package smram_pkg;
  localparam int BIT_OPEN   = 6;
  localparam int BIT_CLOSED = 5;
  localparam int BIT_LOCK   = 4;
  localparam int BIT_ENABLE = 3;
  localparam logic [2:0] FIXED_LOW = 3'b010;

  typedef struct packed {
    logic loadOpen;
    logic loadClosed;
    logic loadEnable;
    logic setLock;
  } regStrobeT;
endpackage

// File: rtl/smram_ctrl.sv
module smram_ctrl
  import smram_pkg::*;
#(
  parameter int CFG_ADDR_W = 8,
  parameter logic [CFG_ADDR_W-1:0] REG_OFFSET = 'h9D
) (
  input  logic                  cfgWrEn,
  input  logic [CFG_ADDR_W-1:0] cfgAddr,
  input  logic [7:0]            cfgWrData,
  input  logic                  lockQ,
  input  logic [7:0]            regImage,
  output regStrobeT             strobe,
  output logic [7:0]            cfgRdData
);
  logic regHit;
  logic wrHit;
  logic unusedWrBits;

  assign regHit = (cfgAddr == REG_OFFSET);
  assign wrHit  = cfgWrEn && regHit;

  // Fields frozen by the lock load only while unlocked; closed always loads.
  always_comb begin
    strobe            = '0;
    strobe.loadClosed = wrHit;
    strobe.loadOpen   = wrHit && !lockQ;
    strobe.loadEnable = wrHit && !lockQ;
    strobe.setLock    = wrHit && !lockQ && cfgWrData[BIT_LOCK];
  end

  assign cfgRdData    = regHit ? regImage : 8'h00;
  assign unusedWrBits = ^{cfgWrData[7], cfgWrData[2:0]};
endmodule

// File: rtl/smram_dp.sv
module smram_dp
  import smram_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = 'hA0000,
  parameter int WIN_LOG2 = 17
) (
  input  logic              clk,
  input  logic              rstFullN,
  input  regStrobeT         strobe,
  input  logic [7:0]        wrData,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqSmm,
  input  logic              reqCode,
  output logic [7:0]        regImage,
  output logic              lockQ,
  output logic              routeDram,
  output logic              routeVideo
);
  localparam int TAG_W = ADDR_W - WIN_LOG2;

  logic openQ, closedQ, enableQ;
  logic inWin, smmGrant, plainGrant;
  logic unusedBase;

  always_ff @(posedge clk or negedge rstFullN) begin
    if (!rstFullN) begin
      openQ   <= 1'b0;
      closedQ <= 1'b0;
      lockQ   <= 1'b0;
      enableQ <= 1'b0;
    end else begin
      if (strobe.loadOpen)   openQ   <= wrData[BIT_OPEN] && !wrData[BIT_LOCK];
      if (strobe.loadClosed) closedQ <= wrData[BIT_CLOSED];
      if (strobe.loadEnable) enableQ <= wrData[BIT_ENABLE];
      if (strobe.setLock)    lockQ   <= 1'b1;
    end
  end

  assign regImage = {1'b0, openQ, closedQ, lockQ, enableQ, FIXED_LOW};

  assign inWin      = (reqAddr[ADDR_W-1:WIN_LOG2] == WIN_BASE[ADDR_W-1:WIN_LOG2]);
  assign smmGrant   = reqSmm && (reqCode || !closedQ);
  assign plainGrant = !reqSmm && openQ && !lockQ;

  assign routeDram  = inWin && enableQ && (smmGrant || plainGrant);
  assign routeVideo = inWin && !routeDram;

  assign unusedBase = ^{WIN_BASE[WIN_LOG2-1:0], TAG_W[0]};
endmodule

// File: rtl/smram_guard.sv
module smram_guard
  import smram_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CFG_ADDR_W = 8,
  parameter logic [CFG_ADDR_W-1:0] REG_OFFSET = 'h9D,
  parameter logic [ADDR_W-1:0] WIN_BASE = 'hA0000,
  parameter int WIN_LOG2 = 17
) (
  input  logic                  clk,
  input  logic                  rstFullN,
  input  logic                  cfgWrEn,
  input  logic [CFG_ADDR_W-1:0] cfgAddr,
  input  logic [7:0]            cfgWrData,
  output logic [7:0]            cfgRdData,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic                  reqSmm,
  input  logic                  reqCode,
  output logic                  routeDram,
  output logic                  routeVideo,
  output logic                  lockOut
);
  regStrobeT  strobe;
  logic [7:0] regImage;
  logic       lockQ;

  smram_ctrl #(.CFG_ADDR_W(CFG_ADDR_W), .REG_OFFSET(REG_OFFSET)) u_ctrl (
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .lockQ(lockQ), .regImage(regImage), .strobe(strobe), .cfgRdData(cfgRdData)
  );

  smram_dp #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_LOG2(WIN_LOG2)) u_dp (
    .clk(clk), .rstFullN(rstFullN), .strobe(strobe), .wrData(cfgWrData),
    .reqAddr(reqAddr), .reqSmm(reqSmm), .reqCode(reqCode),
    .regImage(regImage), .lockQ(lockQ),
    .routeDram(routeDram), .routeVideo(routeVideo)
  );

  assign lockOut = lockQ;
endmodule

// File: rtl/smram_guard_chk.sv
module smram_guard_chk #(
  parameter int ADDR_W = 32,
  parameter int CFG_ADDR_W = 8,
  parameter logic [CFG_ADDR_W-1:0] REG_OFFSET = 'h9D,
  parameter logic [ADDR_W-1:0] WIN_BASE = 'hA0000,
  parameter int WIN_LOG2 = 17
) (
  input logic                  clk,
  input logic                  rstFullN,
  input logic                  cfgWrEn,
  input logic [CFG_ADDR_W-1:0] cfgAddr,
  input logic [7:0]            cfgWrData,
  input logic [7:0]            cfgRdData,
  input logic [ADDR_W-1:0]     reqAddr,
  input logic                  reqSmm,
  input logic                  reqCode,
  input logic                  routeDram,
  input logic                  routeVideo,
  input logic                  lockOut
);
  logic inWinChk, selChk;
  assign inWinChk = (reqAddr >= WIN_BASE) && (reqAddr < WIN_BASE + (ADDR_W'(1) << WIN_LOG2));
  assign selChk   = (cfgAddr == REG_OFFSET);

  p_outside_quiet_r3: assert property (@(posedge clk) disable iff (!rstFullN)
    !inWinChk |-> (!routeDram && !routeVideo));

  p_one_route_r3: assert property (@(posedge clk) disable iff (!rstFullN)
    inWinChk |-> (routeDram != routeVideo));

  p_disabled_no_dram_r4: assert property (@(posedge clk) disable iff (!rstFullN)
    (selChk && !cfgRdData[3]) |-> !routeDram);

  p_smm_fetch_r5: assert property (@(posedge clk) disable iff (!rstFullN)
    (selChk && cfgRdData[3] && inWinChk && reqSmm && reqCode) |-> routeDram);

  p_lock_open_low_r8: assert property (@(posedge clk) disable iff (!rstFullN)
    (selChk && lockOut) |-> !cfgRdData[6]);

  p_enable_frozen_r9: assert property (@(posedge clk) disable iff (!rstFullN)
    (selChk && $past(selChk) && lockOut && $past(lockOut)) |-> (cfgRdData[3] == $past(cfgRdData[3])));

  p_lock_sticky_r10: assert property (@(posedge clk) disable iff (!rstFullN)
    lockOut |=> lockOut);

  logic unusedChk;
  assign unusedChk = ^{cfgWrEn, cfgWrData};
endmodule

bind smram_guard smram_guard_chk #(
  .ADDR_W(ADDR_W), .CFG_ADDR_W(CFG_ADDR_W), .REG_OFFSET(REG_OFFSET),
  .WIN_BASE(WIN_BASE), .WIN_LOG2(WIN_LOG2)
) u_chk (
  .clk(clk), .rstFullN(rstFullN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
  .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .reqAddr(reqAddr),
  .reqSmm(reqSmm), .reqCode(reqCode), .routeDram(routeDram),
  .routeVideo(routeVideo), .lockOut(lockOut)
);

// File: tb/tb_smram_guard.sv
`timescale 1ns/1ps
module tb_smram_guard;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rstFullN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [7:0]  cfgAddr = 8'h00;
  logic [7:0]  cfgWrData = 8'h00;
  logic [7:0]  cfgRdData;
  logic [31:0] reqAddr = 32'h0;
  logic        reqSmm = 1'b0;
  logic        reqCode = 1'b0;
  logic        routeDram, routeVideo, lockOut;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // bench model of the register fields
  bit mOpen, mClosed, mLock, mEn;

  always #(CLK_NS/2) clk = ~clk;

  smram_guard dut (
    .clk(clk), .rstFullN(rstFullN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .reqAddr(reqAddr),
    .reqSmm(reqSmm), .reqCode(reqCode), .routeDram(routeDram),
    .routeVideo(routeVideo), .lockOut(lockOut)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstFullN = 1'b0;
    repeat (2) @(negedge clk);
    rstFullN = 1'b1;
    mOpen = 0; mClosed = 0; mLock = 0; mEn = 0;
  endtask

  task automatic cfgWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
    if (a == 8'h9D) begin
      if (!mLock) begin
        mEn = d[3]; mLock = d[4]; mOpen = d[6] && !d[4]; mClosed = d[5];
      end else begin
        mClosed = d[5];
      end
    end
  endtask

  function automatic logic [7:0] expImage();
    return {1'b0, mOpen, mClosed, mLock, mEn, 3'b010};
  endfunction

  task automatic checkRead(input logic [7:0] a, input logic [7:0] exp, input string tag);
    cfgAddr = a;
    #1;
    check(cfgRdData == exp, tag, cfgRdData, exp);
  endtask

  task automatic sweepRequests(input string phase);
    logic [31:0] addrs [7];
    addrs = '{32'h0009_FFFF, 32'h000A_0000, 32'h000B_0000, 32'h000B_FFFF,
              32'h000C_0000, 32'h0000_0000, 32'h100A_0000};
    for (int i = 0; i < 7; i++) begin
      for (int m = 0; m < 4; m++) begin
        bit inWin, expDram, expVid;
        string tag;
        @(negedge clk);
        reqAddr = addrs[i]; reqSmm = m[1]; reqCode = m[0];
        #1;
        inWin   = (addrs[i] >= 32'hA0000) && (addrs[i] <= 32'hBFFFF);
        expDram = inWin && mEn && (m[1] ? (m[0] || !mClosed) : (mOpen && !mLock));
        expVid  = inWin && !expDram;
        if (!inWin) tag = "R3";
        else if (!mEn) tag = "R4";
        else if (mOpen && mClosed) tag = "R7";
        else if (m[1]) tag = "R5";
        else tag = "R6";
        check({routeDram, routeVideo} == {expDram, expVid},
              $sformatf("%s %s addr=%0h smm=%0d code=%0d", tag, phase, addrs[i], m[1], m[0]),
              {routeDram, routeVideo}, {expDram, expVid});
      end
    end
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    doReset();
    // R1 reset state
    checkRead(8'h9D, 8'h02, "R1 reset image");
    check(lockOut == 1'b0, "R1 lockOut after reset", lockOut, 0);
    // R2 other offsets read zero
    checkRead(8'h9C, 8'h00, "R2 other offset reads 0");

    // unlocked sweep over open/closed/enable, with junk in bits 7 and 2:0
    for (int cfg = 0; cfg < 8; cfg++) begin
      logic [7:0] d;
      d = {1'b1, cfg[2] ? 1'b1 : 1'b0, cfg[1] ? 1'b1 : 1'b0, 1'b0, cfg[0] ? 1'b1 : 1'b0, 3'b101};
      cfgWrite(8'h9D, d);
      checkRead(8'h9D, expImage(), "R2 unlocked readback");
      sweepRequests("unlocked");
    end

    // R2 write elsewhere changes nothing (state: open, closed, enable = 1)
    cfgWrite(8'h9C, 8'h00);
    checkRead(8'h9D, 8'h6A, "R2 foreign write ignored");

    // R8 lock write clears open in the same write
    cfgWrite(8'h9D, 8'h78);
    checkRead(8'h9D, 8'h3A, "R8 lock sets, open cleared");
    check(lockOut == 1'b1, "R8 lockOut raised", lockOut, 1);
    sweepRequests("locked");

    // R9/R10: closed follows, lock/enable hold, lock not cleared by 0
    cfgWrite(8'h9D, 8'h00);
    checkRead(8'h9D, 8'h1A, "R9 closed writable, rest frozen");
    check(lockOut == 1'b1, "R10 lock survives write of 0", lockOut, 1);
    cfgWrite(8'h9D, 8'h48);
    checkRead(8'h9D, 8'h1A, "R9 open stays 0 under lock");
    sweepRequests("locked-open-attempt");

    // R10 only full reset clears
    doReset();
    check(lockOut == 1'b0, "R10 reset clears lock", lockOut, 0);
    checkRead(8'h9D, 8'h02, "R10 image after reset");
    cfgWrite(8'h9D, 8'h48);
    checkRead(8'h9D, 8'h4A, "R10 open writable again");
    sweepRequests("after-reset");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule